// File: doc/BRIEF.md
# Iterative Width-Selectable Integer Divider

This block divides one unsigned integer by another using a restoring shift-and-subtract loop. Each clock cycle it settles one quotient bit. A two-bit size code picks the operand width: 8, 16, 32 or 64 bits. The number of cycles an operation takes equals that width. A cycle counter, loaded from the size code when the operation starts, sets both the latency and the time the unit stays occupied.

The unit is not pipelined and holds only one operation at a time. The issue logic watches `busy` and holds back further divides while it is high. A start request that arrives while the unit is busy is dropped. One cycle before the result appears, `wb_req` tells the write-port allocator that the result will need a register-file write slot on the following cycle. The quotient and remainder stay on their outputs until a later operation completes.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done`, `wb_req`, `quotient` and `remainder` are all zero.
- R2: When `start` is sampled high on a clock edge while `busy` is low, `done` goes high exactly W clock edges later. The size code sets W as follows: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64.
- R3: `busy` is high from the edge that accepts `start` until the edge that raises `done`. It falls on the same edge that raises `done`.
- R4: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R5: When `done` is high, `quotient` and `remainder` are the unsigned quotient and remainder of the W-bit dividend and divisor.
- R6: Dividing by zero gives a quotient with all W low bits set to one and a remainder equal to the W-bit dividend.
- R7: Operand bits at position W and above have no effect on the result. Result bits at position W and above read as zero.
- R8: `done` is high for exactly one cycle. `quotient` and `remainder` then hold their values until the next operation completes.
- R9: `wb_req` is high for exactly one cycle, the cycle just before `done` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a divide; ignored while busy |
| size | input | 2 | Operand width code (00=8, 01=16, 10=32, 11=64) |
| dividend | input | 64 | Dividend; bits at position W and above are ignored |
| divisor | input | 64 | Divisor; bits at position W and above are ignored |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result becomes valid |
| wb_req | output | 1 | The result needs a write port on the next cycle |
| quotient | output | 64 | Unsigned quotient, zero-extended from W bits |
| remainder | output | 64 | Unsigned remainder, zero-extended from W bits |

## Verification
The divide is run at all four widths with several operand pairs:
- Small ratios, which leave many quotient bits at zero.
- Divisor equal to one, which gives a quotient equal to the dividend.
- Divisor larger than the dividend, which gives a zero quotient and the whole dividend as remainder.
- Operands at the full width limit, which exercise the borrow out of the top bit.

Zero divisors, and operands with junk in the bits above the selected width, separate correct masking from arithmetic that leaks across widths. A second start issued in the middle of an operation, and a result observed for several idle cycles after it completes, show whether operands and outputs are protected when they should be.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_DOUBLE = 2'b11
    } div_size_e;

    localparam int SIZE_BITS = 2;
endpackage

// File: rtl/div_size_decode.sv
module div_size_decode
    import div_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int MIN_W = 8,
    localparam int CW   = $clog2(XLEN + 1)
) (
    input  logic [SIZE_BITS-1:0] size,
    output logic [CW-1:0]        cnt_init,
    output logic [CW-1:0]        shamt,
    output logic [XLEN-1:0]      mask
);
    always_comb begin
        cnt_init = CW'(MIN_W) << size;
        shamt    = CW'(XLEN) - cnt_init;
    end

    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        assign mask[i] = (CW'(i) < cnt_init);
    end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN:0]   rem_in,
    input  logic [XLEN-1:0] quo_in,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN:0]   rem_out,
    output logic [XLEN-1:0] quo_out
);
    logic [XLEN+1:0] shifted;
    logic [XLEN+1:0] trial;

    always_comb begin
        shifted = {rem_in, quo_in[XLEN-1]};
        trial   = shifted - {2'b00, dvs};
        if (!trial[XLEN+1]) begin
            rem_out = trial[XLEN:0];
            quo_out = {quo_in[XLEN-2:0], 1'b1};
        end else begin
            rem_out = shifted[XLEN:0];
            quo_out = {quo_in[XLEN-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import div_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int MIN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SIZE_BITS-1:0] size,
    input  logic [XLEN-1:0]      dividend,
    input  logic [XLEN-1:0]      divisor,
    output logic                 busy,
    output logic                 done,
    output logic                 wb_req,
    output logic [XLEN-1:0]      quotient,
    output logic [XLEN-1:0]      remainder
);
    localparam int CW = $clog2(XLEN + 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CW-1:0]   cnt;
        logic [XLEN:0]   rem;
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] dvs;
        logic [XLEN-1:0] mask;
        logic [XLEN-1:0] q_out;
        logic [XLEN-1:0] r_out;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0]   cnt_init;
    logic [CW-1:0]   shamt;
    logic [XLEN-1:0] mask;
    logic [XLEN:0]   step_rem;
    logic [XLEN-1:0] step_quo;

    div_size_decode #(.XLEN(XLEN), .MIN_W(MIN_W)) u_dec (
        .size     (size),
        .cnt_init (cnt_init),
        .shamt    (shamt),
        .mask     (mask)
    );

    div_restore_step #(.XLEN(XLEN)) u_step (
        .rem_in  (st_q.rem),
        .quo_in  (st_q.quo),
        .dvs     (st_q.dvs),
        .rem_out (step_rem),
        .quo_out (step_quo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy && start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = cnt_init;
            st_d.rem  = '0;
            st_d.quo  = (dividend & mask) << shamt;
            st_d.dvs  = divisor & mask;
            st_d.mask = mask;
        end else if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.quo = step_quo;
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.q_out = step_quo & st_q.mask;
                st_d.r_out = step_rem[XLEN-1:0] & st_q.mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign wb_req    = st_q.busy && (st_q.cnt == CW'(1));
    assign quotient  = st_q.q_out;
    assign remainder = st_q.r_out;

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("start not taken"); // R3
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))) else $error("done without busy fall"); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(st_q.dvs)) else $error("operand overwritten"); // R4
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.dvs != '0) |-> (remainder < st_q.dvs)) else $error("remainder too big"); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done too long"); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder))) else $error("result moved"); // R8
    AST_WB_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> (done && !wb_req)) else $error("wb_req misplaced"); // R9
endmodule

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        busy, done, wb_req;
    logic [63:0] quotient, remainder;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    iter_divider dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size(size),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .wb_req(wb_req), .quotient(quotient), .remainder(remainder)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] wmask(input logic [1:0] s);
        int w = 8 << s;
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    // Runs one divide; optionally pulses a second start at edge 'poke' with junk operands.
    task automatic run_op(input logic [1:0] s, input logic [63:0] a, input logic [63:0] b,
                          input int poke);
        int w = 8 << s;
        logic [63:0] m = wmask(s);
        logic [63:0] am = a & m;
        logic [63:0] bm = b & m;
        logic [63:0] eq = (bm == 0) ? m : am / bm;
        logic [63:0] er = (bm == 0) ? am : am % bm;
        int edges = 0;
        int wb_seen = 0;
        @(negedge clk);
        size = s; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3 busy after start", {63'd0, busy}, 64'd1);
        while (!done && edges < 200) begin
            check("R9 wb_req timing", {63'd0, wb_req}, {63'd0, edges == w - 1});
            if (wb_req) wb_seen++;
            if (edges + 1 != w) check("R3 busy during op", {63'd0, busy}, 64'd1);
            if (edges == poke) begin
                dividend = ~a; divisor = 64'd3; size = ~s; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            edges++;
        end
        start = 1'b0;
        check("R2 latency", 64'(edges), 64'(w));
        check("R3 busy low at done", {63'd0, busy}, 64'd0);
        check("R9 wb_req single", 64'(wb_seen), 64'd1);
        check("R5 R6 R7 quotient", quotient, eq);
        check("R5 R6 R7 remainder", remainder, er);
        @(negedge clk);
        check("R8 done one cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 wb_req", {63'd0, wb_req}, 64'd0);
        check("R1 quotient", quotient, 64'd0);
        check("R1 remainder", remainder, 64'd0);
    endtask

    task automatic t_basic();   // R2 R5
        run_op(2'b00, 64'd200, 64'd7, -1);
        run_op(2'b01, 64'd60000, 64'd1, -1);
        run_op(2'b10, 64'd12345, 64'd99999, -1);
        run_op(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, -1);
        run_op(2'b11, 64'h8000_0000_0000_0001, 64'd3, -1);
        run_op(2'b10, 64'hFFFF_FFFF, 64'h8000_0000, -1);
    endtask

    task automatic t_divzero(); // R6
        run_op(2'b00, 64'd77, 64'd0, -1);
        run_op(2'b11, 64'h1234_5678_9ABC_DEF0, 64'd0, -1);
    endtask

    task automatic t_upper(); // R7: high junk must not change result
        run_op(2'b00, 64'hDEAD_BEEF_0000_00F0, 64'hFFFF_FFFF_FFFF_FF10, -1);
        run_op(2'b01, 64'hAAAA_0000_0000_1000, 64'h5555_0000_0000_0000, -1);
        run_op(2'b10, 64'hFFFF_FFFF_0000_0064, 64'h0000_0001_0000_000A, -1);
    endtask

    task automatic t_busy_ignore(); // R4
        run_op(2'b01, 64'd50000, 64'd123, 5);
        run_op(2'b00, 64'd255, 64'd16, 6);
    endtask

    task automatic t_hold(); // R8
        logic [63:0] q0, r0;
        run_op(2'b00, 64'd100, 64'd9, -1);
        q0 = quotient; r0 = remainder;
        dividend = 64'd5; divisor = 64'd2;
        repeat (4) @(negedge clk);
        check("R8 quotient held", quotient, q0);
        check("R8 remainder held", remainder, r0);
        check("R8 done stays low", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_divzero();
        t_upper();
        t_busy_ignore();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule